// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small direct-mapped table that the fetch stage consults with the current program counter in the same cycle that the instruction word is read. Each slot remembers one recently resolved branch: which address it lived at, where it went, and whether it should be steered to that destination. When the lookup hits, the fetch stage already knows that the word being fetched is a branch and where it goes. When the slot's hint says taken, the next fetch address is the remembered destination. The fetch stage can then follow a taken branch on the very next cycle. There is no redirect bubble from the decode stage, which would otherwise flush one wrongly fetched instruction.

Later pipeline stages train the table through an update port. When a branch resolves, they present its address, its destination and its outcome, and the indexed slot is written or overwritten. Lookups are purely combinational, so a lookup in the same cycle as an update to that slot still sees the previous contents. The new contents appear from the following cycle. Reset empties the table.

The word offset (two low PC bits) is ignored. The slot index is the next `IDX_W` bits up, and the remaining upper bits form the tag.

Top module: `btb_top`

## Requirements
- R1: After reset every lookup misses: `lk_hit` = 0 and `lk_taken` = 0 for any PC, and `lk_next_pc` = `lk_pc` + 4.
- R2: After an update with `upd_taken` = 1 at PC p, a lookup of p gives `lk_hit` = 1, `lk_taken` = 1 and `lk_target` equal to the written target, until that slot is overwritten.
- R3: After an update with `upd_taken` = 0 at PC p, a lookup of p gives `lk_hit` = 1 and `lk_taken` = 0, with `lk_target` equal to the written target. `lk_taken` is never 1 without `lk_hit`.
- R4: On a miss, or on a hit whose hint is not taken, `lk_next_pc` = `lk_pc` + 4, computed modulo 2^PC_W.
- R5: A PC whose index bits `pc[IDX_W+1:2]` match a valid slot but whose upper tag bits differ misses.
- R6: An update overwrites the indexed slot whatever it held before. This covers a different tag, which evicts the old branch, and the same tag, which replaces the hint and the target.
- R7: A lookup in the same cycle as an update to the same slot returns the slot's old contents. The new contents are returned from the next cycle on.
- R8: When `lk_taken` = 1, `lk_next_pc` equals `lk_target`.
- R9: An update to one index does not change lookups of PCs that map to other indices.
- R10: If no update occurs in a cycle, a lookup of the same PC in the following cycle returns the same hit, hint and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all valid bits |
| lk_pc | input | PC_W | Fetch-stage PC to look up |
| lk_hit | output | 1 | Slot valid and tag matches: the fetched word is a known branch |
| lk_taken | output | 1 | Hit and the stored hint is taken |
| lk_target | output | PC_W | Stored destination of the slot (meaningful when `lk_hit` = 1) |
| lk_next_pc | output | PC_W | Next fetch address: target when predicted taken, else `lk_pc` + 4 |
| upd_valid | input | 1 | Write the update fields into the indexed slot at the clock edge |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved destination of the branch |
| upd_taken | input | 1 | Resolved outcome, stored as the slot's hint |

## Verification
Training a slot and looking up that same slot can fall in the same cycle. The vector table provokes this by driving an update and a lookup of the same PC in one row. This is done for an empty slot, for an eviction by an aliasing tag, and for a hint change on the same branch. In that row the lookup result is judged against the slot's old contents, and in the following row against the newly written contents. Aliasing PCs and PCs at other indices are looked up around these writes to confirm that only the addressed slot changed.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Bytes per instruction word; the PC offset bits below the index
    localparam int WORD_BYTES = 4;
    localparam int OFS_W      = $clog2(WORD_BYTES);

    // Classification of one lookup
    typedef enum logic [1:0] {
        LK_MISS      = 2'd0,
        LK_HIT_SEQ   = 2'd1,
        LK_HIT_REDIR = 2'd2
    } lk_kind_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    always_comb begin
        idx = pc[OFS_W +: IDX_W];
        tag = pc[PC_W-1 -: TAG_W];
    end

    // Word offset bits are not part of the address key
    logic unused_ofs;
    assign unused_ofs = &{1'b0, pc[OFS_W-1:0]};

endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic             wr_hint,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    output logic             rd_hint
);

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem  [DEPTH];
    logic [PC_W-1:0]  tgt_mem  [DEPTH];
    logic             hint_mem [DEPTH];

    // Valid bits: one reset flop per slot
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[s] <= 1'b0;
            end else if (sel) begin
                valid_q[s] <= 1'b1;
            end
        end

        // Payload needs no reset: it is only read behind a set valid bit
        always_ff @(posedge clk) begin
            if (rst_n && sel) begin
                tag_mem[s]  <= wr_tag;
                tgt_mem[s]  <= wr_tgt;
                hint_mem[s] <= wr_hint;
            end
        end
    end

    // Asynchronous read: same-cycle reads see pre-edge contents
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_tgt   = tgt_mem[rd_idx];
        rd_hint  = hint_mem[rd_idx];
    end

endmodule

// File: rtl/btb_predict.sv
module btb_predict
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [PC_W-1:0]  rd_tgt,
    input  logic             rd_hint,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  next_pc
);

    lk_kind_e kind;
    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc = lk_pc + PC_W'(WORD_BYTES);
        if (!(rd_valid && (rd_tag == lk_tag))) begin
            kind = LK_MISS;
        end else if (rd_hint) begin
            kind = LK_HIT_REDIR;
        end else begin
            kind = LK_HIT_SEQ;
        end
    end

    always_comb begin
        target = rd_tgt;
        unique case (kind)
            LK_MISS: begin
                hit     = 1'b0;
                taken   = 1'b0;
                next_pc = seq_pc;
            end
            LK_HIT_SEQ: begin
                hit     = 1'b1;
                taken   = 1'b0;
                next_pc = seq_pc;
            end
            LK_HIT_REDIR: begin
                hit     = 1'b1;
                taken   = 1'b1;
                next_pc = rd_tgt;
            end
            default: begin
                hit     = 1'b0;
                taken   = 1'b0;
                next_pc = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken
);

    localparam int TAG_W = PC_W - IDX_W - OFS_W;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             rd_valid, rd_hint;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_tgt;

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_split (
        .pc  (upd_pc),
        .idx (up_idx),
        .tag (up_tag)
    );

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (upd_target),
        .wr_hint  (upd_taken),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_hint  (rd_hint)
    );

    btb_predict #(.PC_W(PC_W), .TAG_W(TAG_W)) u_predict (
        .lk_pc    (lk_pc),
        .lk_tag   (lk_tag),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_hint  (rd_hint),
        .hit      (lk_hit),
        .taken    (lk_taken),
        .target   (lk_target),
        .next_pc  (lk_next_pc)
    );

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_target,
    input logic [PC_W-1:0] lk_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_taken
);

    logic armed;
    logic fresh;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        fresh <= !rst_n;
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit); // R3

    AST_REDIRECT_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> (lk_next_pc == lk_target)); // R8

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> (lk_next_pc == lk_pc + PC_W'(4))); // R4

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> !lk_hit); // R1

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(upd_valid) && (lk_pc == $past(upd_pc))) |->
        (lk_hit && (lk_target == $past(upd_target)) && (lk_taken == $past(upd_taken)))); // R2

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(upd_valid) && $stable(lk_pc)) |->
        ($stable(lk_hit) && $stable(lk_taken) && $stable(lk_target))); // R10

endmodule

bind btb_top btb_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .lk_taken   (lk_taken),
    .lk_target  (lk_target),
    .lk_next_pc (lk_next_pc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_target (upd_target),
    .upd_taken  (upd_taken)
);

// File: tb/sim_btb_top.sv
module sim_btb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] lk_pc;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target, lk_next_pc;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc, upd_target;
    logic            upd_taken;

    always #10 clk = ~clk; // 50 MHz

    btb_top #(.PC_W(PC_W), .IDX_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic [7:0]  req;
        logic        upd;
        logic [31:0] upc;
        logic [31:0] utgt;
        logic        utk;
        logic [31:0] lpc;
        logic        ehit;
        logic        etk;
        logic [31:0] etgt;
        logic [31:0] enext;
    } vec_t;

    // Index is pc[5:2]. 0x1000 and 0x2000 share slot 0 with different tags;
    // 0x1014 is slot 5, 0x1038 is slot 14.
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'd4,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    32'h1004}, // R4 empty
        '{8'd7,  1'b1, 32'h1000, 32'h0800, 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0, 32'h1004}, // R7 old
        '{8'd2,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1000, 1'b1, 1'b1, 32'h0800, 32'h0800}, // R2 R8
        '{8'd7,  1'b1, 32'h1014, 32'h3000, 1'b0, 32'h1014, 1'b0, 1'b0, 32'h0, 32'h1018}, // R7
        '{8'd3,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1014, 1'b1, 1'b0, 32'h3000, 32'h1018}, // R3
        '{8'd5,  1'b0, 32'h0, 32'h0, 1'b0, 32'h2000, 1'b0, 1'b0, 32'h0,    32'h2004}, // R5 alias
        '{8'd7,  1'b1, 32'h2000, 32'h0400, 1'b1, 32'h1000, 1'b1, 1'b1, 32'h0800, 32'h0800}, // R7
        '{8'd6,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    32'h1004}, // R6 evicted
        '{8'd6,  1'b0, 32'h0, 32'h0, 1'b0, 32'h2000, 1'b1, 1'b1, 32'h0400, 32'h0400}, // R6 new
        '{8'd9,  1'b1, 32'h1038, 32'h5000, 1'b1, 32'h1014, 1'b1, 1'b0, 32'h3000, 32'h1018}, // R9
        '{8'd9,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1038, 1'b1, 1'b1, 32'h5000, 32'h5000}, // R9
        '{8'd7,  1'b1, 32'h1014, 32'h3300, 1'b1, 32'h1014, 1'b1, 1'b0, 32'h3000, 32'h1018}, // R7
        '{8'd6,  1'b0, 32'h0, 32'h0, 1'b0, 32'h1014, 1'b1, 1'b1, 32'h3300, 32'h3300}  // R6 same tag
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic look(input string tag, input logic [31:0] pc,
                        input logic ehit, input logic etk,
                        input logic [31:0] etgt, input logic [31:0] enext);
        lk_pc = pc;
        #5;
        chk(tag, "hit",   {31'b0, lk_hit},   {31'b0, ehit});
        chk(tag, "taken", {31'b0, lk_taken}, {31'b0, etk});
        chk(tag, "next",  lk_next_pc, enext);
        if (ehit) chk(tag, "target", lk_target, etgt);
    endtask

    task automatic write(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_target = '0;
        upd_taken = 1'b0; lk_pc = 32'h1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        @(negedge clk);
        look("R1", 32'h1000, 1'b0, 1'b0, 32'h0, 32'h1004);
        look("R1", 32'h103C, 1'b0, 1'b0, 32'h0, 32'h1040);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            upd_valid  = VEC[i].upd;
            upd_pc     = VEC[i].upc;
            upd_target = VEC[i].utgt;
            upd_taken  = VEC[i].utk;
            look($sformatf("R%0d row%0d", VEC[i].req, i), VEC[i].lpc,
                 VEC[i].ehit, VEC[i].etk, VEC[i].etgt, VEC[i].enext);
        end
        @(negedge clk);
        upd_valid = 1'b0;

        // R10: no write, repeated lookup stays the same
        @(negedge clk);
        look("R10", 32'h1038, 1'b1, 1'b1, 32'h5000, 32'h5000);
        @(negedge clk);
        look("R10", 32'h1038, 1'b1, 1'b1, 32'h5000, 32'h5000);

        // R4: sequential address wraps at the top of the space
        look("R4 wrap", 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0, 32'h0000_0000);
        // R2: highest slot and all-ones tag
        write(32'hFFFF_FFFC, 32'h0000_0010, 1'b1);
        look("R2 top", 32'hFFFF_FFFC, 1'b1, 1'b1, 32'h10, 32'h10);
        // R5: same slot 15 from a low address misses
        look("R5 slot15", 32'h0000_003C, 1'b0, 1'b0, 32'h0, 32'h40);

        // R1: reset in mid-run empties every slot
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look("R1 rerst", 32'h1038, 1'b0, 1'b0, 32'h0, 32'h103C);
        look("R1 rerst", 32'h2000, 1'b0, 1'b0, 32'h0, 32'h2004);
        look("R1 rerst", 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule